// File: doc/BRIEF.md
# I2C Slave Interface with Debounced Clock Input

This block is a slave-only I2C port with a small processor register interface. It watches two open-drain lines. It detects START, repeated START and STOP. It compares the incoming 7-bit address with an address that software programs. On a match it acknowledges and then either takes bytes from the bus or sends bytes onto it. The R/W bit that follows the address picks the direction. One shared data register carries every byte in both directions. Software loads it before a byte goes out and reads it after a byte has come in.

Both lines pass through a two-flop synchronizer. The clock line then passes through a debounce filter that software can set to zero, one or two system clocks. A clock glitch no longer than the chosen setting does not advance the bit counter. The block pulls SDA low or releases it and never drives SCL. A flag and a one-cycle interrupt pulse mark each matched address and each completed data byte.

Software sets the own address and the enable bit, then answers each interrupt. It reads received bytes from the data register, or writes the next byte to send into it. Register offsets on the CPU port: 0 = control, 1 = own address, 2 = data, 3 = status.

Top module: `i2cs_top`

## Requirements
- R1: The block never drives SCL (`scl_oe` stays 0). It only pulls SDA low through `sda_oe`; the high level comes from the external pull-up.
- R2: When control bit 0 (enable) is 0, the block ignores the bus. It gives no acknowledge, leaves the data register unchanged, raises no interrupt and keeps SDA released.
- R3: After a START, the first 8 bits are read MSB first as a 7-bit address plus an R/W bit. The block acknowledges (pulls SDA low in the ninth clock) only when the address equals bits [6:0] of register 1. On a mismatch it leaves SDA released until the next START.
- R4: With R/W = 0 (slave receive), every data byte is acknowledged. The byte is stored in the data register (offset 2) when its eighth bit has been taken.
- R5: With R/W = 1 (slave transmit), the data register contents are sent MSB first. The register is copied into the shifter at the falling SCL edge that ends the address acknowledge, and again at the falling edge that ends each acknowledged data byte.
- R6: In slave transmit, a NACK (SDA high in the acknowledge clock) from the master ends the transfer. SDA then stays released until the next START.
- R7: Status bit 3 (done) is set and `irq` pulses for exactly one cycle after each address match and after each data byte. Writing 1 to status bit 3 clears the flag.
- R8: Status bit 0 is 1 from an address match until the STOP. Bit 1 gives the direction (1 = transmit). Bit 2 holds the last acknowledge bit sampled from the master (1 = NACK).
- R9: A repeated START in the middle of a byte discards the partial byte, clears the bit count and returns the block to address reception.
- R10: Control bits [2:1] select the SCL debounce: 0 = none, 1 = one clock, 2 or 3 = two clocks. With a setting of N, an SCL pulse lasting N system clocks or fewer is ignored.
- R11: After reset, all four registers read 0, SDA is released and `irq` is low.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | Register access strobe |
| cpu_wr | input | 1 | Write when 1, with cpu_en |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr (combinational) |
| irq | output | 1 | One-cycle pulse per matched address or data byte |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | SCL pull-low enable (always 0) |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | SDA pull-low enable |

## Verification
The assertions assume the master holds SDA steady for longer than the synchronizer and debounce delay after each SCL fall. They also assume each SCL phase outlasts the debounce setting, so the filtered clock is still low when the block changes its drive. They assume the debounce setting changes only while the bus is idle, because the hold-time check measures a fixed window against the current setting. The stimulus uses quarter-bit periods of 20 system clocks and reprograms the control register only between transactions. It injects glitches only in the low phase of SCL, and never longer than the active setting.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_SKIP
    } eng_state_t;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_OWN  = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam int SB_DONE = 3;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic nack;
        logic tx;
        logic match;
    } eng_stat_t;

    function automatic logic [3:0] stat_nibble(input logic done, input eng_stat_t s);
        return {done, s.nack, s.tx, s.match};
    endfunction

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [CNT_W-1:0] deb_lim,
    output bus_evt_t         evt,
    output logic             scl_lvl,
    output logic             scl_syn
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic                   scl_f, scl_p, sda_p;
    logic [CNT_W-1:0]       cnt;
    logic                   scl_s, sda_s;

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_f    <= 1'b1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            cnt      <= '0;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_p    <= scl_f;
            sda_p    <= sda_s;
            if (scl_s == scl_f) begin
                cnt <= '0;
            end else if (cnt >= deb_lim) begin
                scl_f <= scl_s;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        evt.rise  = scl_f & ~scl_p;
        evt.fall  = ~scl_f & scl_p;
        evt.start = scl_f & scl_p & sda_p & ~sda_s;
        evt.stop  = scl_f & scl_p & ~sda_p & sda_s;
        evt.sda   = sda_s;
    end

    assign scl_lvl = scl_f;
    assign scl_syn = scl_s;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 7,
    parameter int MAX_DEB = 2,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_en,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             rx_load,
    input  logic [DW-1:0]    rx_byte,
    input  logic             done_set,
    input  eng_stat_t        stat,
    output logic             en,
    output logic [CNT_W-1:0] deb_lim,
    output logic [AW-1:0]    own_addr,
    output logic [DW-1:0]    data_q
);
    logic             wr;
    logic             en_q, done_q;
    logic [CNT_W-1:0] deb_sel;
    logic [AW-1:0]    own_q;

    assign wr = cpu_en & cpu_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            deb_sel <= '0;
            own_q   <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            if (wr && cpu_addr == RA_CTRL) begin
                en_q    <= cpu_wdata[0];
                deb_sel <= cpu_wdata[CNT_W:1];
            end
            if (wr && cpu_addr == RA_OWN)
                own_q <= cpu_wdata[AW-1:0];
            if (rx_load)
                data_q <= rx_byte;
            else if (wr && cpu_addr == RA_DATA)
                data_q <= cpu_wdata;
            if (done_set)
                done_q <= 1'b1;
            else if (wr && cpu_addr == RA_STAT && cpu_wdata[SB_DONE])
                done_q <= 1'b0;
        end
    end

    assign en       = en_q;
    assign own_addr = own_q;
    assign deb_lim  = (deb_sel > CNT_W'(MAX_DEB)) ? CNT_W'(MAX_DEB) : deb_sel;

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            RA_CTRL: cpu_rdata[CNT_W:0] = {deb_sel, en_q};
            RA_OWN:  cpu_rdata[AW-1:0]  = own_q;
            RA_DATA: cpu_rdata          = data_q;
            default: cpu_rdata[3:0]     = stat_nibble(done_q, stat);
        endcase
    end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  bus_evt_t      evt,
    input  logic [AW-1:0] own_addr,
    input  logic [DW-1:0] data_q,
    output logic          sda_oe,
    output logic          rx_load,
    output logic [DW-1:0] rx_byte,
    output logic          done_pulse,
    output eng_stat_t     stat
);
    localparam int CW = $clog2(DW);

    eng_state_t    state;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          full, oe, match, tx, nack, done, load;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sh    <= '0;
            cnt   <= '0;
            full  <= 1'b0;
            oe    <= 1'b0;
            match <= 1'b0;
            tx    <= 1'b0;
            nack  <= 1'b0;
            done  <= 1'b0;
            load  <= 1'b0;
        end else begin
            done <= 1'b0;
            load <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
                match <= 1'b0;
                full  <= 1'b0;
            end else if (evt.start) begin
                state <= ST_ADDR;
                cnt   <= '0;
                full  <= 1'b0;
                oe    <= 1'b0;
                match <= 1'b0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
                match <= 1'b0;
                full  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (evt.rise) begin
                            sh  <= {sh[DW-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                            if (cnt == CW'(DW-1)) full <= 1'b1;
                        end else if (evt.fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (sh[DW-1:1] == own_addr) begin
                                    match <= 1'b1;
                                    tx    <= sh[0];
                                    nack  <= 1'b0;
                                    oe    <= 1'b1;
                                    done  <= 1'b1;
                                    state <= ST_AACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                load  <= 1'b1;
                                done  <= 1'b1;
                                oe    <= 1'b1;
                                state <= ST_RACK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.fall) begin
                            if (tx) begin
                                sh    <= data_q;
                                oe    <= ~data_q[DW-1];
                                state <= ST_TX;
                            end else begin
                                oe    <= 1'b0;
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.fall) begin
                            oe    <= 1'b0;
                            state <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (evt.rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == CW'(DW-1)) full <= 1'b1;
                        end else if (evt.fall) begin
                            if (full) begin
                                full  <= 1'b0;
                                cnt   <= '0;
                                oe    <= 1'b0;
                                state <= ST_TACK;
                            end else begin
                                sh <= {sh[DW-2:0], 1'b0};
                                oe <= ~sh[DW-2];
                            end
                        end
                    end
                    ST_TACK: begin
                        if (evt.rise) begin
                            nack <= evt.sda;
                            done <= 1'b1;
                        end else if (evt.fall) begin
                            if (nack) begin
                                state <= ST_SKIP;
                            end else begin
                                sh    <= data_q;
                                oe    <= ~data_q[DW-1];
                                state <= ST_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe     = oe;
    assign rx_load    = load;
    assign rx_byte    = sh;
    assign done_pulse = done;
    assign stat       = '{nack: nack, tx: tx, match: match};

endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 7,
    parameter int MAX_DEB     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_en,
    input  logic          cpu_wr,
    input  logic [1:0]    cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq,
    input  logic          scl_i,
    output logic          scl_oe,
    input  logic          sda_i,
    output logic          sda_oe
);
    localparam int CNT_W = $clog2(MAX_DEB + 1);

    bus_evt_t         evt;
    eng_stat_t        eng_stat;
    logic             ctl_en, scl_lvl, scl_syn, rx_load, done_pulse;
    logic [CNT_W-1:0] deb_lim;
    logic [AW-1:0]    own_addr;
    logic [DW-1:0]    data_q, rx_byte;

    i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .deb_lim (deb_lim),
        .evt     (evt),
        .scl_lvl (scl_lvl),
        .scl_syn (scl_syn)
    );

    i2cs_regs #(.DW(DW), .AW(AW), .MAX_DEB(MAX_DEB), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_en    (cpu_en),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .done_set  (done_pulse),
        .stat      (eng_stat),
        .en        (ctl_en),
        .deb_lim   (deb_lim),
        .own_addr  (own_addr),
        .data_q    (data_q)
    );

    i2cs_engine #(.DW(DW), .AW(AW)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl_en),
        .evt        (evt),
        .own_addr   (own_addr),
        .data_q     (data_q),
        .sda_oe     (sda_oe),
        .rx_load    (rx_load),
        .rx_byte    (rx_byte),
        .done_pulse (done_pulse),
        .stat       (eng_stat)
    );

    assign irq    = done_pulse;
    assign scl_oe = 1'b0;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             sda_oe,
    input logic             scl_f,
    input logic             scl_s,
    input logic             irq,
    input logic             match,
    input logic             tx,
    input logic             rx_load,
    input logic             stop_evt,
    input logic [CNT_W-1:0] deb_lim
);
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_oe && !irq));

    assert_drive_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> match);

    assert_store_in_receive_R4: assert property (@(posedge clk) disable iff (rst)
        rx_load |-> (match && !tx));

    assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_stop_drops_match_R8: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !match);

    assert_deb_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (deb_lim == CNT_W'(2) && $changed(scl_f)) |->
            ($past(scl_s, 1) == scl_f && $past(scl_s, 2) == scl_f && $past(scl_s, 3) == scl_f));

    assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

endmodule

bind i2cs_top i2cs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (ctl_en),
    .sda_oe   (sda_oe),
    .scl_f    (scl_lvl),
    .scl_s    (scl_syn),
    .irq      (irq),
    .match    (eng_stat.match),
    .tx       (eng_stat.tx),
    .rx_load  (rx_load),
    .stop_evt (evt.stop),
    .deb_lim  (deb_lim)
);

// File: tb/i2cs_top_bench.sv
module i2cs_top_bench;
    localparam int Q = 20;
    localparam logic [6:0] OWN = 7'h5A;
    // {addr7, rw, data, expected ack, expected result}
    localparam logic [24:0] VEC [0:7] = '{
        {7'h5A, 1'b0, 8'h3C, 1'b0, 8'h3C},
        {7'h5A, 1'b0, 8'hC3, 1'b0, 8'hC3},
        {7'h5B, 1'b0, 8'hFF, 1'b1, 8'hC3},
        {7'h5A, 1'b1, 8'hA5, 1'b0, 8'hA5},
        {7'h2D, 1'b1, 8'h81, 1'b1, 8'hFF},
        {7'h5A, 1'b1, 8'h00, 1'b0, 8'h00},
        {7'h5A, 1'b0, 8'h00, 1'b0, 8'h00},
        {7'h1A, 1'b0, 8'h77, 1'b1, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_en = 1'b0, cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00, cpu_rdata;
    logic irq, scl_oe, sda_oe, scl_i, sda_i;
    logic m_scl = 1'b1, m_sda = 1'b1;

    int checks = 0, errors = 0, irq_cnt = 0;
    bit scl_oe_seen = 1'b0, r12_bad = 1'b0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    assign scl_i = m_scl & ~scl_oe;
    assign sda_i = m_sda & ~sda_oe;

    i2cs_top u_i2cs_top (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .scl_i(scl_i), .scl_oe(scl_oe), .sda_i(sda_i), .sda_oe(sda_oe)
    );

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (scl_oe) scl_oe_seen = 1'b1;
        if (sda_oe !== oe_prev && scl_i) r12_bad = 1'b1;
        oe_prev = sda_oe;
    end

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        report();
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_en = 1'b1; cpu_wr = 1'b1;
        tick(1);
        cpu_en = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a;
        #2;
        d = cpu_rdata;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_bit_glitch(input logic b, input int w);
        m_sda = b; tick(Q / 2);
        m_scl = 1'b1; tick(w);
        m_scl = 1'b0; tick(Q - Q / 2 - w);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_i; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(ack);
    endtask

    task automatic read_byte(output logic [7:0] d, input logic ack);
        logic b;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        send_bit(ack);
    endtask

    task automatic glitch_write(input logic [7:0] d, input int w, input string req);
        logic ack;
        logic [7:0] r;
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        chk(req, "address ack with debounce", {31'd0, ack}, 32'd0);
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) send_bit_glitch(d[i], w);
            else send_bit(d[i]);
        end
        get_bit(ack);
        chk(req, "data ack after glitch", {31'd0, ack}, 32'd0);
        bus_stop();
        cpu_read(2'd2, r);
        chk(req, "byte survives glitch", {24'd0, r}, {24'd0, d});
    endtask

    initial begin
        logic ack, a2;
        logic [7:0] r, b1, b2, b3;
        int base;

        tick(5);
        rst = 1'b0;
        tick(2);

        // R11: reset state
        chk("R11", "sda_oe after reset", {31'd0, sda_oe}, 32'd0);
        chk("R11", "irq after reset", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            cpu_read(a[1:0], r);
            chk("R11", "register after reset", {24'd0, r}, 32'd0);
        end

        cpu_write(2'd1, {1'b0, OWN});
        cpu_write(2'd0, 8'h01);
        cpu_read(2'd0, r);
        chk("R10", "control readback", {24'd0, r}, 32'h01);

        // R3 R4 R5: vector table
        for (int v = 0; v < 8; v++) begin
            logic [6:0] va;
            logic       vrw, vack;
            logic [7:0] vd, vres;
            {va, vrw, vd, vack, vres} = VEC[v];
            if (vrw) cpu_write(2'd2, vd);
            bus_start();
            write_byte({va, vrw}, ack);
            chk("R3", "address ack", {31'd0, ack}, {31'd0, vack});
            if (!vrw) begin
                write_byte(vd, a2);
                chk("R4", "data ack", {31'd0, a2}, {31'd0, vack});
                bus_stop();
                cpu_read(2'd2, r);
                chk("R4", "data register after write", {24'd0, r}, {24'd0, vres});
            end else begin
                read_byte(r, 1'b1);
                bus_stop();
                chk("R5", "byte read by master", {24'd0, r}, {24'd0, vres});
            end
        end

        // R7 R8: two-byte receive, flag and pulse count
        cpu_write(2'd3, 8'h08);
        base = irq_cnt;
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        write_byte(8'h11, ack);
        write_byte(8'h22, ack);
        cpu_read(2'd3, r);
        chk("R8", "status during receive", {24'd0, r}, 32'h09);
        bus_stop();
        chk("R7", "irq pulses for address plus two bytes", irq_cnt - base, 3);
        cpu_read(2'd2, r);
        chk("R4", "last byte kept", {24'd0, r}, 32'h22);
        cpu_read(2'd3, r);
        chk("R8", "status after stop", {24'd0, r}, 32'h08);
        cpu_write(2'd3, 8'h08);
        cpu_read(2'd3, r);
        chk("R7", "done cleared by write one", {24'd0, r}, 32'h00);

        // R5 R6 R8: two-byte transmit with reload, then NACK
        cpu_write(2'd2, 8'h96);
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R5", "read address ack", {31'd0, ack}, 32'd0);
        cpu_read(2'd3, r);
        chk("R8", "status transmit matched", {24'd0, r}, 32'h0B);
        cpu_write(2'd2, 8'hE7);
        read_byte(b1, 1'b0);
        read_byte(b2, 1'b1);
        chk("R5", "first sent byte", {24'd0, b1}, 32'h96);
        chk("R5", "reloaded second byte", {24'd0, b2}, 32'hE7);
        cpu_read(2'd3, r);
        chk("R8", "status records NACK", {24'd0, r}, 32'h0F);
        read_byte(b3, 1'b1);
        chk("R6", "SDA released after NACK", {24'd0, b3}, 32'hFF);
        bus_stop();

        // R9: repeated start mid-byte
        cpu_write(2'd2, 8'h5C);
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R9", "address ack after repeated start", {31'd0, ack}, 32'd0);
        read_byte(r, 1'b1);
        chk("R9", "byte sent after repeated start", {24'd0, r}, 32'h5C);
        bus_stop();
        cpu_read(2'd2, r);
        chk("R9", "partial byte discarded", {24'd0, r}, 32'h5C);

        // R2: disabled block ignores the bus
        cpu_write(2'd0, 8'h00);
        cpu_write(2'd2, 8'h33);
        base = irq_cnt;
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R2", "no address ack when disabled", {31'd0, ack}, 32'd1);
        write_byte(8'h44, ack);
        chk("R2", "no data ack when disabled", {31'd0, ack}, 32'd1);
        bus_stop();
        cpu_read(2'd2, r);
        chk("R2", "data unchanged when disabled", {24'd0, r}, 32'h33);
        chk("R2", "no irq when disabled", irq_cnt - base, 0);

        // R10: debounce settings
        cpu_write(2'd0, 8'h05);
        cpu_read(2'd0, r);
        chk("R10", "control readback two clocks", {24'd0, r}, 32'h05);
        glitch_write(8'hA6, 2, "R10");
        cpu_write(2'd0, 8'h03);
        glitch_write(8'h59, 1, "R10");
        cpu_write(2'd0, 8'h07);
        glitch_write(8'h3E, 2, "R10");

        // R1 R12: line behaviour over the whole run
        chk("R1", "SCL never driven", {31'd0, scl_oe_seen}, 32'd0);
        chk("R12", "SDA drive changed only with SCL low", {31'd0, r12_bad}, 32'd0);

        report();
    end

endmodule